// File: doc/BRIEF.md
# Descriptor Ring Completion Engine

This block is the hardware side of one descriptor ring shared between a host driver and the device. The driver fills in descriptors in host memory and moves the ring's head index forward to post them. Whenever the tail index trails the head index, the engine takes the descriptor at the tail. It computes that descriptor's host address from the ring base, offers it to a processing port and waits for a result code. It then requests a write of a completion word back to the descriptor, with the top bit marking hardware ownership as finished. When that write is acknowledged, the engine steps the tail, wrapping at the ring size.

Each finished descriptor adds one completion credit. The first completion after the ring is armed raises a single-cycle interrupt request. The ring then stays masked, whatever the vector-level masking does, until the driver has given back every credit by writing counts to the credit register. Host memory traffic and descriptor payload decoding are outside the block. They are reached through a plain valid/ack request port and a valid/done processing port.

The register slot uses 32-bit words, selected by a 3-bit word index (byte offset divided by four). Word 0 holds the low half of the base address and word 1 the high half. Word 2 is the size, word 3 the head, word 4 the tail (read-only), word 5 the control (write-only, reads 0) and word 6 the credit count. Word 7 reads 0.

Top module: `desc_ring_engine`

## Requirements
- R1: The base address occupies words 0 (bits 31:0) and 1 (bits 63:32). Bits 2:0 are forced to zero on write, so word 0 always reads back with its low three bits clear.
- R2: A head write (word 3) whose value is below the current size is stored. A head write whose value is greater than or equal to the size leaves head unchanged and pulses `head_fault_o` high for exactly the cycle after the write.
- R3: Writes to the tail word (word 4) are ignored, and the tail reads back unchanged.
- R4: While tail differs from head, the engine raises `proc_valid_o` with `proc_addr_o` = base + tail*32. It holds both until `proc_done_i`, and serves descriptors strictly in index order.
- R5: After `proc_done_i`, the engine raises `wb_valid_o` with `wb_addr_o` = base + tail*32 + 24 and `wb_data_o` = {1'b1, proc_err_i[30:0]} as captured with done. Bit 31 is the done flag. Codes 0 = success, 1 = address/data read error, 2 = invalid parameter, 3 = buffer too small.
- R6: On the cycle `wb_ack_i` is accepted, tail becomes tail+1, or 0 when tail+1 equals size.
- R7: Each completion adds one to the credit count (word 6). Writing N to word 6 subtracts N, saturating at zero.
- R8: A completion while the ring is armed gives a one-cycle `irq_o` pulse in the following cycle and disarms the ring. While disarmed, no completion raises `irq_o`. A credit write that leaves the count at zero re-arms it.
- R9: Writing word 5 with bit 0 set clears head, tail and credits, re-arms the interrupt and abandons any descriptor in flight. Word 5 reads 0, and writes with bit 0 clear have no effect.
- R10: After reset all register words read 0, the ring is armed and every output strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Word index within the ring slot |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| head_fault_o | output | 1 | Pulse: rejected head write |
| proc_valid_o | output | 1 | Descriptor offered for processing |
| proc_addr_o | output | 64 | Host address of offered descriptor |
| proc_done_i | input | 1 | Processing finished, result on `proc_err_i` |
| proc_err_i | input | 32 | Result code, low 31 bits used |
| wb_valid_o | output | 1 | Completion write request |
| wb_addr_o | output | 64 | Host address of completion word |
| wb_data_o | output | 32 | Completion word with done flag |
| wb_ack_i | input | 1 | Completion write accepted |
| irq_o | output | 1 | Ring interrupt request pulse |

## Verification
The assertions assume well-behaved partner ports. `proc_done_i` is pulsed only while `proc_valid_o` is high, and `wb_ack_i` is pulsed only while `wb_valid_o` is high. They also assume that the size is not shrunk below live indices while descriptors are pending. The stimulus keeps to this: done and ack are driven only after the matching valid is seen, and the size changes only after a ring reset. A credit return never lands in the same cycle as a completion, because credits are written only between serviced descriptors.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PROC, ST_WB} ring_st_e;

  localparam logic [2:0] W_BASE_LO = 3'd0;
  localparam logic [2:0] W_BASE_HI = 3'd1;
  localparam logic [2:0] W_SIZE    = 3'd2;
  localparam logic [2:0] W_HEAD    = 3'd3;
  localparam logic [2:0] W_TAIL    = 3'd4;
  localparam logic [2:0] W_CTRL    = 3'd5;
  localparam logic [2:0] W_CRED    = 3'd6;

  localparam int CTRL_RESET_BIT = 0;

  localparam logic [30:0] CODE_OK      = 31'd0;
  localparam logic [30:0] CODE_IO      = 31'd1;
  localparam logic [30:0] CODE_INVAL   = 31'd2;
  localparam logic [30:0] CODE_MSGSIZE = 31'd3;
endpackage

// File: rtl/desc_ring_regs.sv
module desc_ring_regs
  import desc_ring_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int CRED_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic [IDX_W-1:0]  tail_i,
  input  logic [CRED_W-1:0] cred_i,
  output logic [31:0]       reg_rdata_o,
  output logic [63:0]       base_o,
  output logic [IDX_W-1:0]  size_o,
  output logic [IDX_W-1:0]  head_o,
  output logic              ring_rst_o,
  output logic              cred_wr_o,
  output logic              head_fault_o
);
  logic [63:0]      base_q;
  logic [IDX_W-1:0] size_q, head_q;
  logic             fault_q;
  logic             wr_head, head_ok;

  assign wr_head    = reg_wr_i && (reg_addr_i == W_HEAD);
  assign head_ok    = reg_wdata_i < 32'(size_q);
  assign ring_rst_o = reg_wr_i && (reg_addr_i == W_CTRL) && reg_wdata_i[CTRL_RESET_BIT];
  assign cred_wr_o  = reg_wr_i && (reg_addr_i == W_CRED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      size_q  <= '0;
      head_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      fault_q <= wr_head && !head_ok;
      if (ring_rst_o) head_q <= '0;
      else if (wr_head && head_ok) head_q <= reg_wdata_i[IDX_W-1:0];
      if (reg_wr_i) begin
        case (reg_addr_i)
          W_BASE_LO: base_q[31:0]  <= {reg_wdata_i[31:3], 3'b000};
          W_BASE_HI: base_q[63:32] <= reg_wdata_i;
          W_SIZE:    size_q        <= reg_wdata_i[IDX_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr_i)
      W_BASE_LO: reg_rdata_o = base_q[31:0];
      W_BASE_HI: reg_rdata_o = base_q[63:32];
      W_SIZE:    reg_rdata_o = 32'(size_q);
      W_HEAD:    reg_rdata_o = 32'(head_q);
      W_TAIL:    reg_rdata_o = 32'(tail_i);
      W_CRED:    reg_rdata_o = 32'(cred_i);
      default:   reg_rdata_o = '0;
    endcase
  end

  assign base_o       = base_q;
  assign size_o       = size_q;
  assign head_o       = head_q;
  assign head_fault_o = fault_q;
endmodule

// File: rtl/desc_ring_seq.sv
module desc_ring_seq
  import desc_ring_pkg::*;
#(
  parameter int IDX_W       = 16,
  parameter int ERR_W       = 32,
  parameter int DESC_SHIFT  = 5,
  parameter int COMP_OFFSET = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [63:0]      base_i,
  input  logic [IDX_W-1:0] size_i,
  input  logic [IDX_W-1:0] head_i,
  input  logic             ring_rst_i,
  input  logic             proc_done_i,
  input  logic [ERR_W-1:0] proc_err_i,
  input  logic             wb_ack_i,
  output logic [IDX_W-1:0] tail_o,
  output logic             proc_valid_o,
  output logic [63:0]      proc_addr_o,
  output logic             wb_valid_o,
  output logic [63:0]      wb_addr_o,
  output logic [ERR_W-1:0] wb_data_o,
  output logic             complete_o
);
  localparam int CODE_W = ERR_W - 1;

  ring_st_e          st_q;
  logic [IDX_W-1:0]  tail_q, tail_inc;
  logic [CODE_W-1:0] code_q;
  logic [63:0]       desc_addr;
  logic              pending;

  assign pending    = tail_q != head_i;
  assign tail_inc   = (tail_q + 1'b1 == size_i) ? '0 : tail_q + 1'b1;
  assign desc_addr  = base_i + (64'(tail_q) << DESC_SHIFT);
  assign complete_o = (st_q == ST_WB) && wb_ack_i && !ring_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      tail_q <= '0;
      code_q <= '0;
    end else if (ring_rst_i) begin
      st_q   <= ST_IDLE;
      tail_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (pending) st_q <= ST_PROC;
        ST_PROC: if (proc_done_i) begin
          code_q <= proc_err_i[CODE_W-1:0];
          st_q   <= ST_WB;
        end
        ST_WB: if (wb_ack_i) begin
          tail_q <= tail_inc;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign tail_o       = tail_q;
  assign proc_valid_o = st_q == ST_PROC;
  assign proc_addr_o  = desc_addr;
  assign wb_valid_o   = st_q == ST_WB;
  assign wb_addr_o    = desc_addr + 64'(COMP_OFFSET);
  assign wb_data_o    = {1'b1, code_q};
endmodule

// File: rtl/desc_ring_credit.sv
module desc_ring_credit #(
  parameter int CRED_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ring_rst_i,
  input  logic              complete_i,
  input  logic              cred_wr_i,
  input  logic [31:0]       cred_wdata_i,
  output logic [CRED_W-1:0] cred_o,
  output logic              irq_o
);
  localparam int SUM_W = (CRED_W > 32 ? CRED_W : 32) + 1;

  logic [CRED_W-1:0] cred_q, cred_nxt;
  logic [SUM_W-1:0]  sum, dec;
  logic              armed_q, irq_q;

  assign sum      = SUM_W'(cred_q) + SUM_W'(complete_i);
  assign dec      = cred_wr_i ? SUM_W'(cred_wdata_i) : '0;
  assign cred_nxt = (dec > sum) ? '0 : CRED_W'(sum - dec);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cred_q  <= '0;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else if (ring_rst_i) begin
      cred_q  <= '0;
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      cred_q <= cred_nxt;
      irq_q  <= complete_i && armed_q;
      if (complete_i && armed_q) armed_q <= 1'b0;
      else if (cred_wr_i && cred_nxt == '0) armed_q <= 1'b1;
    end
  end

  assign cred_o = cred_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/desc_ring_engine.sv
module desc_ring_engine
  import desc_ring_pkg::*;
#(
  parameter int IDX_W       = 16,
  parameter int CRED_W      = 16,
  parameter int ERR_W       = 32,
  parameter int DESC_SHIFT  = 5,
  parameter int COMP_OFFSET = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             head_fault_o,
  output logic             proc_valid_o,
  output logic [63:0]      proc_addr_o,
  input  logic             proc_done_i,
  input  logic [ERR_W-1:0] proc_err_i,
  output logic             wb_valid_o,
  output logic [63:0]      wb_addr_o,
  output logic [ERR_W-1:0] wb_data_o,
  input  logic             wb_ack_i,
  output logic             irq_o
);
  logic [63:0]       base;
  logic [IDX_W-1:0]  size, head, tail;
  logic [CRED_W-1:0] cred;
  logic              ring_rst, cred_wr, complete;

  desc_ring_regs #(.IDX_W(IDX_W), .CRED_W(CRED_W)) u_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i,
    .tail_i(tail), .cred_i(cred), .reg_rdata_o,
    .base_o(base), .size_o(size), .head_o(head),
    .ring_rst_o(ring_rst), .cred_wr_o(cred_wr), .head_fault_o
  );

  desc_ring_seq #(
    .IDX_W(IDX_W), .ERR_W(ERR_W), .DESC_SHIFT(DESC_SHIFT), .COMP_OFFSET(COMP_OFFSET)
  ) u_seq (
    .clk_i, .rst_ni, .base_i(base), .size_i(size), .head_i(head),
    .ring_rst_i(ring_rst), .proc_done_i, .proc_err_i, .wb_ack_i,
    .tail_o(tail), .proc_valid_o, .proc_addr_o, .wb_valid_o, .wb_addr_o,
    .wb_data_o, .complete_o(complete)
  );

  desc_ring_credit #(.CRED_W(CRED_W)) u_cred (
    .clk_i, .rst_ni, .ring_rst_i(ring_rst), .complete_i(complete),
    .cred_wr_i(cred_wr), .cred_wdata_i(reg_wdata_i), .cred_o(cred), .irq_o
  );
endmodule

// File: rtl/desc_ring_engine_chk.sv
module desc_ring_engine_chk
  import desc_ring_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int CRED_W = 16,
  parameter int ERR_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [2:0]        reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic [IDX_W-1:0]  size,
  input logic [IDX_W-1:0]  head,
  input logic [IDX_W-1:0]  tail,
  input logic [CRED_W-1:0] cred,
  input logic              complete,
  input logic              ring_rst,
  input logic              head_fault_o,
  input logic              proc_valid_o,
  input logic [63:0]       proc_addr_o,
  input logic              proc_done_i,
  input logic              wb_valid_o,
  input logic [ERR_W-1:0]  wb_data_o,
  input logic              irq_o
);
  p_head_reject_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i == W_HEAD && reg_wdata_i >= 32'(size)
    |=> head_fault_o && $stable(head));

  p_tail_moves_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tail) |-> $past(complete || ring_rst));

  p_proc_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    proc_valid_o && !proc_done_i && !ring_rst |=> proc_valid_o && $stable(proc_addr_o));

  p_done_flag_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> wb_data_o[ERR_W-1]);

  p_cred_inc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete && !ring_rst && !(reg_wr_i && reg_addr_i == W_CRED)
    |=> cred == $past(cred) + 1'b1);

  p_irq_owes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cred != '0);

  p_irq_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_ring_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring_rst |=> head == '0 && tail == '0 && cred == '0 && !proc_valid_o);

  p_exclusive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(proc_valid_o && wb_valid_o));
endmodule

bind desc_ring_engine desc_ring_engine_chk #(
  .IDX_W(IDX_W), .CRED_W(CRED_W), .ERR_W(ERR_W)
) u_chk (
  .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i,
  .size, .head, .tail, .cred, .complete, .ring_rst,
  .head_fault_o, .proc_valid_o, .proc_addr_o, .proc_done_i,
  .wb_valid_o, .wb_data_o, .irq_o
);

// File: tb/desc_ring_engine_bench.sv
module desc_ring_engine_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        head_fault_o, proc_valid_o, wb_valid_o, irq_o;
  logic [63:0] proc_addr_o, wb_addr_o;
  logic        proc_done_i = 1'b0, wb_ack_i = 1'b0;
  logic [31:0] proc_err_i = '0;
  logic [31:0] wb_data_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [63:0] m_base;
  int m_size, m_head, m_tail, m_cred;
  bit m_armed;

  always #4 clk = ~clk;

  desc_ring_engine u_desc_ring_engine (
    .clk_i(clk), .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .head_fault_o, .proc_valid_o, .proc_addr_o, .proc_done_i, .proc_err_i,
    .wb_valid_o, .wb_addr_o, .wb_data_o, .wb_ack_i, .irq_o
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic ring_reset();
    wr(3'd5, 32'h1);
    m_head = 0; m_tail = 0; m_cred = 0; m_armed = 1;
  endtask

  task automatic ret_cred(input int n);
    wr(3'd6, n);
    m_cred = (n > m_cred) ? 0 : m_cred - n;
    if (m_cred == 0) m_armed = 1;
  endtask

  task automatic serve(input logic [30:0] code);
    logic [31:0] v;
    int n = 0;
    while (!proc_valid_o && n < 50) begin @(negedge clk); n++; end
    chk("R4 proc_valid", proc_valid_o, 1);
    chk("R4 proc_addr", proc_addr_o, m_base + 64'(m_tail) * 32);
    proc_err_i = {1'b0, code}; proc_done_i = 1'b1;
    @(negedge clk);
    proc_done_i = 1'b0;
    chk("R5 wb_valid", wb_valid_o, 1);
    chk("R5 wb_addr", wb_addr_o, m_base + 64'(m_tail) * 32 + 24);
    chk("R5 wb_data", wb_data_o, {1'b1, code});
    wb_ack_i = 1'b1;
    @(negedge clk);
    wb_ack_i = 1'b0;
    m_tail = (m_tail + 1 == m_size) ? 0 : m_tail + 1;
    m_cred++;
    chk("R8 irq on completion", irq_o, m_armed);
    m_armed = 0;
    rd(3'd4, v); chk("R6 tail", v, m_tail);
    rd(3'd6, v); chk("R7 credits", v, m_cred);
    @(negedge clk);
    chk("R8 irq single cycle", irq_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10 reset state
    for (int w = 0; w < 8; w++) begin
      rd(w[2:0], v); chk("R10 reset word", v, 0);
    end
    chk("R10 strobes low", {proc_valid_o, wb_valid_o, irq_o, head_fault_o}, 0);
    m_head = 0; m_tail = 0; m_cred = 0; m_armed = 1;

    // R1 base alignment
    wr(3'd0, 32'h1234_5677);
    rd(3'd0, v); chk("R1 base low aligned", v, 32'h1234_5670);
    wr(3'd1, 32'h0000_000a);
    rd(3'd1, v); chk("R1 base high", v, 32'h0000_000a);
    m_base = 64'h0000_000a_1234_5670;

    // Sweep sizes: rejections, tail write ignored, wrap over several laps
    for (int s = 1; s <= 5; s++) begin
      ring_reset();
      wr(3'd2, s); m_size = s;
      rd(3'd5, v); chk("R9 ctrl reads zero", v, 0);
      for (int k = 0; k < 2 * s + 1; k++) begin
        for (int bad = s; bad <= s + 3; bad += 3) begin
          @(negedge clk);
          reg_wr_i = 1'b1; reg_addr_i = 3'd3; reg_wdata_i = bad;
          @(negedge clk);
          reg_wr_i = 1'b0;
          chk("R2 fault pulse", head_fault_o, 1);
          rd(3'd3, v); chk("R2 head kept", v, m_head);
          @(negedge clk);
          chk("R2 fault single cycle", head_fault_o, 0);
        end
        wr(3'd4, 32'h1);
        rd(3'd4, v); chk("R3 tail write ignored", v, m_tail);
        if (s > 1) begin
          m_head = (m_head + 1) % s;
          wr(3'd3, m_head);
          chk("R2 accepted no fault", head_fault_o, 0);
          rd(3'd3, v); chk("R2 head stored", v, m_head);
          serve(31'(k % 4));
          ret_cred(1);
          rd(3'd6, v); chk("R7 credit return", v, m_cred);
        end
      end
    end

    // Interrupt masking across several completions
    ring_reset();
    wr(3'd2, 8); m_size = 8;
    m_head = 3; wr(3'd3, 3);
    serve(31'd1); serve(31'd2); serve(31'd3);
    ret_cred(1);
    m_head = 4; wr(3'd3, 4);
    serve(31'd0);
    rd(3'd6, v); chk("R7 credits while masked", v, 3);
    ret_cred(5);
    rd(3'd6, v); chk("R7 saturating return", v, 0);
    m_head = 5; wr(3'd3, 5);
    serve(31'd2);
    ret_cred(1);

    // Control write without reset bit has no effect
    wr(3'd5, 32'h2);
    rd(3'd3, v); chk("R9 ctrl bit0 clear keeps head", v, m_head);
    rd(3'd4, v); chk("R9 ctrl bit0 clear keeps tail", v, m_tail);

    // Ring reset with a descriptor in flight
    m_head = 7; wr(3'd3, 7);
    begin
      int n = 0;
      while (!proc_valid_o && n < 50) begin @(negedge clk); n++; end
    end
    chk("R4 in flight", proc_valid_o, 1);
    wr(3'd5, 32'h1);
    m_head = 0; m_tail = 0; m_cred = 0; m_armed = 1;
    chk("R9 abandoned", {proc_valid_o, wb_valid_o}, 0);
    rd(3'd3, v); chk("R9 head cleared", v, 0);
    rd(3'd4, v); chk("R9 tail cleared", v, 0);
    rd(3'd6, v); chk("R9 credits cleared", v, 0);
    m_head = 1; wr(3'd3, 1);
    serve(31'd3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule